// File: doc/BRIEF.md
# Twelve-Channel Write-Only Serial Latch Slave

This block is a write-only slave on a two-wire I2C bus. It keeps twelve 8-bit values, one per output channel, and drives them as parallel buses. These buses are meant to feed external converters. The block oversamples SCL and SDA with a fast system clock, at least sixteen times the bus clock, and recognises START and STOP conditions. A write transaction has three bytes: a device address, a channel-select byte and a value byte. The block answers each accepted byte with an acknowledge, which it gives by pulling SDA low through an open-drain enable.

The device address is a fixed upper nibble `1001`, followed by three bits that must equal the `chip_sel` pins, followed by the read/write bit. A transaction that does not address the device is left alone until the next START. Each transaction updates at most one channel. Channel codes that name no channel are acknowledged but change nothing.

The block has no data streams. Every pin is a plain control or data level, so there is no valid/ready back-pressure at its edge.

Top module: `i2c_chan_latch`

## Requirements
- R1: The first byte after a START is acknowledged only when its upper four bits are `1001` and its bits 3..1 equal `chip_sel[2:0]`. Any other first byte gets no acknowledge, and the rest of the transaction changes no channel.
- R2: A first byte whose bit 0 (the read/write bit) is 1 gets no acknowledge, and the transaction is ignored.
- R3: After the eighth bit of an accepted byte, `sda_oe` rises while SCL is low. It stays high through the whole high phase of the ninth SCL clock and drops after SCL falls again.
- R4: In the second byte, bits 7..4 are ignored. Bits 3..0 form a channel code n. Codes 1 to 12 select channel n, which is held in `ch_vals[(n-1)*8 +: 8]`.
- R5: Channel codes 0, 13, 14 and 15 select no channel. The second and third bytes are still acknowledged, but no channel changes.
- R6: The third byte arrives most significant bit first and becomes the new value of the selected channel.
- R7: A START seen in any state, including in the middle of a transaction, begins address reception again.
- R8: Bytes after the third byte get no acknowledge and change no channel. A third byte cut short by STOP before its eighth bit changes no channel.
- R9: An active-low asynchronous reset clears all twelve channels to 0x00, releases `sda_oe` and returns the receiver to idle.
- R10: Between two system clock edges, at most one channel value changes.
- R11: An SDA edge counts as START (falling) or STOP (rising) only while SCL is high. SDA changes made at the same moment SCL falls (zero hold time) are treated as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge); 0 releases it |
| chip_sel | input | 3 | Pin-strapped low three bits of the device address |
| ch_vals | output | 96 | Twelve channel values; channel n occupies bits [(n-1)*8 +: 8] |

## Verification
The bench sweeps every `chip_sel` setting against every strapped address. An address comparator that is off by one bit, or reversed, would acknowledge the wrong setting. It also sends all sixteen channel codes. This catches an off-by-one decode, which would write the wrong channel or let codes 0 and 13 to 15 through. Every data bit changes at the same moment SCL falls, so a START/STOP detector that does not require SCL to be high would abort transfers. Further tests send a repeated START in the middle of a transaction, an extra fourth byte and a third byte cut short by STOP. A design that kept stale state, acknowledged the extra byte or wrote a partial byte would show a wrong channel value or a wrong acknowledge.

// File: rtl/i2cl_pkg.sv
package i2cl_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 4;
  localparam logic [3:0] DEV_PREFIX = 4'b1001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/i2cl_sync.sv
module i2cl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic q_rise,
  output logic q_fall
);
  // Synchroniser chain plus one extra flop that holds the previous value.
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;              // idle bus reads high
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign q      = chain[STAGES-1];
  assign q_rise = chain[STAGES-1] & ~chain[STAGES];
  assign q_fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2cl_rx.sv
module i2cl_rx
  import i2cl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [2:0]        chip_sel,
  output logic              ack_drv,
  output logic              busy,
  output logic              wr_en,
  output logic [CODE_W-1:0] wr_code,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 2);

  rx_state_t         st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [CODE_W-1:0] chan;
  logic              in_ack;
  logic              ack_pend;
  logic [BYTE_W-1:0] byte_now;
  logic              start_c, stop_c, addr_ok;

  // An SDA edge is a bus condition only when SCL was already high before it.
  assign start_c  = scl & ~scl_rise & sda_fall;
  assign stop_c   = scl & ~scl_rise & sda_rise;
  assign byte_now = {shreg[BYTE_W-2:0], sda};
  assign addr_ok  = (byte_now[7:4] == DEV_PREFIX) &&
                    (byte_now[3:1] == chip_sel) && !byte_now[0];
  assign busy     = (st == ST_ADDR) || (st == ST_SUB) || (st == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      chan     <= '0;
      in_ack   <= 1'b0;
      ack_pend <= 1'b0;
      ack_drv  <= 1'b0;
      wr_en    <= 1'b0;
      wr_code  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        st      <= ST_ADDR;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        ack_drv <= 1'b0;
      end else if (stop_c) begin
        st      <= ST_IDLE;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        ack_drv <= 1'b0;
      end else if (busy) begin
        if (scl_rise && bit_cnt != CNT_W'(BYTE_W)) begin
          shreg   <= byte_now;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
            ack_pend <= 1'b1;
            case (st)
              ST_ADDR: if (!addr_ok) begin
                st       <= ST_SKIP;
                ack_pend <= 1'b0;
              end
              ST_SUB:  chan <= byte_now[CODE_W-1:0];
              ST_DATA: begin
                wr_en   <= 1'b1;
                wr_code <= chan;
                wr_data <= byte_now;
              end
              default: ;
            endcase
          end
        end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
          if (!in_ack) begin
            in_ack  <= 1'b1;
            ack_drv <= ack_pend;
          end else begin
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
            bit_cnt <= '0;
            case (st)
              ST_ADDR: st <= ST_SUB;
              ST_SUB:  st <= ST_DATA;
              default: st <= ST_SKIP;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cl_bank.sv
module i2cl_bank
  import i2cl_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CODE_W-1:0]        wr_code,
  input  logic [BYTE_W-1:0]        wr_data,
  output logic [NUM_CH*BYTE_W-1:0] ch_vals
);
  // Channel n answers to code n; code 0 and codes above NUM_CH hit nothing.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [BYTE_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val <= '0;
      else if (wr_en && wr_code == CODE_W'(i + 1))
        val <= wr_data;
    end
    assign ch_vals[i*BYTE_W +: BYTE_W] = val;
  end
endmodule

// File: rtl/i2c_chan_latch.sv
module i2c_chan_latch
  import i2cl_pkg::*;
#(
  parameter int NUM_CH      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_in,
  input  logic                     sda_in,
  output logic                     sda_oe,
  input  logic [2:0]               chip_sel,
  output logic [NUM_CH*BYTE_W-1:0] ch_vals
);
  logic scl_s, scl_r, scl_f;
  logic sda_s, sda_r, sda_f;
  logic rx_busy, wr_en;
  logic [CODE_W-1:0] wr_code;
  logic [BYTE_W-1:0] wr_data;

  i2cl_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_in),
    .q(scl_s), .q_rise(scl_r), .q_fall(scl_f)
  );

  i2cl_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_in),
    .q(sda_s), .q_rise(sda_r), .q_fall(sda_f)
  );

  i2cl_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .scl(scl_s), .scl_rise(scl_r), .scl_fall(scl_f),
    .sda(sda_s), .sda_rise(sda_r), .sda_fall(sda_f),
    .chip_sel(chip_sel),
    .ack_drv(sda_oe), .busy(rx_busy),
    .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data)
  );

  i2cl_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
    .ch_vals(ch_vals)
  );
endmodule

// File: rtl/i2cl_chk.sv
module i2cl_chk #(
  parameter int NUM_CH = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              sda_oe,
  input logic              busy,
  input logic [NUM_CH*8-1:0] ch_vals
);
  function automatic int diff_bytes(input logic [NUM_CH*8-1:0] a,
                                    input logic [NUM_CH*8-1:0] b);
    int n = 0;
    for (int i = 0; i < NUM_CH; i++)
      if (a[i*8 +: 8] != b[i*8 +: 8]) n++;
    return n;
  endfunction

  AST_ACK_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_in); // R3

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |=> sda_oe); // R3

  AST_ACK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy); // R1

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    diff_bytes(ch_vals, $past(ch_vals)) <= 1); // R10

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (ch_vals == '0 && !sda_oe); // R9
    end
  end
endmodule

bind i2c_chan_latch i2cl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .busy(rx_busy), .ch_vals(ch_vals)
);

// File: tb/i2c_chan_latch_test.sv
module i2c_chan_latch_test;
  localparam int NCH = 12;
  localparam int Q   = 6;   // quarter SCL period in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] csel = 3'd0;
  logic sda_oe;
  logic [NCH*8-1:0] ch_vals;
  logic [NCH*8-1:0] exp_v = '0;
  logic sda_line;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_chan_latch uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .chip_sel(csel), .ch_vals(ch_vals)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [NCH*8-1:0] act,
                     input logic [NCH*8-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // SDA changes at the very moment SCL falls: zero hold time (R11).
  task automatic put_bit(input logic b);
    scl_m = 1'b0; sda_m = b; wait_clk(2*Q);
    scl_m = 1'b1; wait_clk(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    scl_m = 1'b0; sda_m = 1'b1; wait_clk(2*Q);
    scl_m = 1'b1; wait_clk(Q);
    acked = (sda_line == 1'b0);
    wait_clk(Q);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; sda_m = 1'b1; wait_clk(2*Q);
    scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b0; wait_clk(2*Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; wait_clk(2*Q);
    scl_m = 1'b1; wait_clk(2*Q);
    sda_m = 1'b1; wait_clk(2*Q);
  endtask

  task automatic write3(input logic [7:0] a, input logic [7:0] s,
                        input logic [7:0] d, output logic [2:0] acks);
    logic k;
    bus_start();
    send_byte(a, k); acks[2] = k;
    send_byte(s, k); acks[1] = k;
    send_byte(d, k); acks[0] = k;
  endtask

  function automatic logic [7:0] dev_addr(input logic [2:0] cs, input logic rd);
    return {4'b1001, cs, rd};
  endfunction

  initial begin
    logic k;
    logic [2:0] acks;
    logic [7:0] dv;

    wait_clk(4);
    // R9: state under reset
    chk("R9 reset ch_vals", ch_vals, '0);
    chk("R9 reset sda_oe", {95'd0, sda_oe}, '0);
    rst_n = 1'b1;
    wait_clk(4);

    // R1: every strap against every address; ack only on a match
    for (int c = 0; c < 8; c++) begin
      csel = 3'(c);
      for (int a = 0; a < 8; a++) begin
        bus_start();
        send_byte(dev_addr(3'(a), 1'b0), k);
        chk("R1 address match ack", {95'd0, k}, {95'd0, (a == c)});
        bus_stop();
      end
    end

    csel = 3'd5;
    // R1: wrong fixed prefix
    bus_start(); send_byte(8'h3A, k);
    chk("R1 prefix nack", {95'd0, k}, '0);
    bus_stop();

    // R1: mismatched strap, full transaction, nothing written
    write3(dev_addr(3'd4, 1'b0), 8'h03, 8'hEE, acks);
    chk("R1 mismatch acks", {93'd0, acks}, '0);
    bus_stop();
    chk("R1 mismatch no write", ch_vals, exp_v);

    // R2: read bit set
    write3(dev_addr(3'd5, 1'b1), 8'h03, 8'hEE, acks);
    chk("R2 read nack", {93'd0, acks}, '0);
    bus_stop();
    chk("R2 read no write", ch_vals, exp_v);

    // R4 R5 R6: all sixteen channel codes, upper nibble varied
    for (int code = 0; code < 16; code++) begin
      dv = 8'((code * 37 + 90) % 256);
      write3(dev_addr(3'd5, 1'b0), {4'(code ^ 10), 4'(code)}, dv, acks);
      chk("R5 acks on all codes", {93'd0, acks}, {93'd0, 3'b111});
      // R3: released after ninth clock
      scl_m = 1'b0; wait_clk(2*Q);
      chk("R3 release after ack", {95'd0, sda_oe}, '0);
      bus_stop();
      if (code >= 1 && code <= NCH) exp_v[(code-1)*8 +: 8] = dv;
      chk("R4 R6 channel decode and value", ch_vals, exp_v);
    end

    // R6: alternating bit pattern arrives MSB first
    write3(dev_addr(3'd5, 1'b0), 8'h01, 8'hA5, acks);
    bus_stop();
    exp_v[0 +: 8] = 8'hA5;
    chk("R6 msb first", ch_vals, exp_v);

    // R8: extra fourth byte gets no ack and writes nothing
    write3(dev_addr(3'd5, 1'b0), 8'h0C, 8'h3C, acks);
    send_byte(8'h99, k);
    chk("R8 extra byte nack", {95'd0, k}, '0);
    bus_stop();
    exp_v[11*8 +: 8] = 8'h3C;
    chk("R8 extra byte no write", ch_vals, exp_v);

    // R8: data byte cut short by STOP
    bus_start();
    send_byte(dev_addr(3'd5, 1'b0), k);
    send_byte(8'h02, k);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_stop();
    chk("R8 truncated byte no write", ch_vals, exp_v);

    // R7: repeated START after the channel byte restarts reception
    bus_start();
    send_byte(dev_addr(3'd5, 1'b0), k);
    send_byte(8'h03, k);
    write3(dev_addr(3'd5, 1'b0), 8'h04, 8'h5A, acks);
    chk("R7 restart acks", {93'd0, acks}, {93'd0, 3'b111});
    bus_stop();
    exp_v[3*8 +: 8] = 8'h5A;
    chk("R7 restart write target", ch_vals, exp_v);

    // R9: asynchronous reset clears every channel
    wait_clk(3);
    #2 rst_n = 1'b0;
    #1 chk("R9 async clear", ch_vals, '0);
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    chk("R9 cleared after release", ch_vals, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule